// File: doc/BRIEF.md
# Host bridge register bank

This block holds the control registers of a CPU-to-PCI host bridge in a 4 KB window of 32-bit words. A single request port carries a valid strobe, a write flag, a 12-bit byte address and 32-bit write data. Writes take effect at the clock edge that accepts them. Reads return their word one cycle after the request, flagged by a response strobe.

Each register has its own write behaviour. Some keep only certain bits. One also loads a shadow remap copy. Some ignore writes. The interrupt cause word can only be cleared, by writing zeros, and its bit 0 summarises the other bits. Bit 12 of the CPU configuration word selects byte order: while it is clear, write data and read data are both byte-reversed across the 32 bits.

From the stored low and high I/O decode values, the block continuously produces the base and size of the PCI I/O window and a flag telling whether the window is valid. Response sequencing uses two states. `ST_IDLE` means no response is pending. `ST_RESP` means read data is being presented. A read request moves the machine to `ST_RESP` from either state. Any other cycle returns it to `ST_IDLE`.

Top module: `hb_regbank`

## Requirements
- R1: After reset, the following words hold these values: CPU config (0x000) 0x00001000, I/O low decode (0x048) 0x80, I/O high decode (0x050) 0x0F, internal-space decode (0x068) 0xA0, I/O remap (0x0F0) 0x80, multi-unit word (0x120) 0x3. Every other word holds 0.
- R2: The word is selected by address bits 11:2. Bits 1:0 have no effect on the word that is read or written.
- R3: `rsp_valid` is high in the cycle after a read request and low in the cycle after any cycle without one. `rsp_rdata` carries the word that was addressed.
- R4: A write to 0x048 stores the data ANDed with 0x7FFF, and also loads the remap word 0x0F0 with the data ANDed with 0x7FF.
- R5: A write to 0x050 keeps bits 6:0 only. A write to 0x068 keeps bits 14:0 only.
- R6: Writes are masked as follows: 0xC1C with 0x3C3FFFFE, 0xC24 with 0x03FFFFFE, 0xC28 with 0x3F, and 0xC00 with 0x0401FC0F.
- R7: A write to 0xC18 ANDs the stored bits 31:1 with write bits 31:1, so written zeros clear bits and no bit can be set. Bit 0 then reads as the OR of bits 31:1.
- R8: Writes to 0x120, 0x070, 0x078, 0x0C0 and 0x0C8 leave those words unchanged.
- R9: While bit 12 of word 0x000 is 0, write data is byte-reversed before it is stored, and read data is byte-reversed before it is returned.
- R10: Let L be the I/O low decode value and H the I/O high decode value. `win_base` = L<<21. `win_valid` = (L[6:0] <= H). `win_size` = (H+1-L[6:0])<<21 when the window is valid, and 0 otherwise.
- R11: A write to any other offset stores all 32 bits unchanged and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| win_base | output | 36 | PCI I/O window base address |
| win_size | output | 29 | PCI I/O window size in bytes |
| win_valid | output | 1 | Window bounds are consistent |

## Verification
The bench builds the block with its default parameters: a 12-bit address, which exposes all 1024 words, and a window shift of 21, which gives a 36-bit base and a 29-bit size. With these values the bench can reach the widest base (low value 0x7FFF), the smallest valid window of 2 MB, and the off-by-one boundary where the low and high values are equal or differ by one. A behavioural word-array model tracks every write. It is compared against the response and window outputs on every clock, in both byte orders.

// File: rtl/hb_regbank_pkg.sv
package hb_regbank_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    // word indices (byte offset >> 2)
    localparam int IDX_CPU_CFG   = 'h000;
    localparam int IDX_IO_LO     = 'h012;
    localparam int IDX_IO_HI     = 'h014;
    localparam int IDX_ISD       = 'h01A;
    localparam int IDX_ERR_LO    = 'h01C;
    localparam int IDX_ERR_HI    = 'h01E;
    localparam int IDX_SYNC0     = 'h030;
    localparam int IDX_SYNC1     = 'h032;
    localparam int IDX_IO_REMAP  = 'h03C;
    localparam int IDX_MULTI     = 'h048;
    localparam int IDX_PCI_CMD   = 'h300;
    localparam int IDX_CAUSE     = 'h306;
    localparam int IDX_INT_MASK  = 'h307;
    localparam int IDX_PCI_IMASK = 'h309;
    localparam int IDX_SERR_MASK = 'h30A;

    localparam logic [DATA_W-1:0] MSK_IO_LO     = 32'h0000_7FFF;
    localparam logic [DATA_W-1:0] MSK_REMAP     = 32'h0000_07FF;
    localparam logic [DATA_W-1:0] MSK_IO_HI     = 32'h0000_007F;
    localparam logic [DATA_W-1:0] MSK_ISD       = 32'h0000_7FFF;
    localparam logic [DATA_W-1:0] MSK_INT_MASK  = 32'h3C3F_FFFE;
    localparam logic [DATA_W-1:0] MSK_PCI_IMASK = 32'h03FF_FFFE;
    localparam logic [DATA_W-1:0] MSK_SERR_MASK = 32'h0000_003F;
    localparam logic [DATA_W-1:0] MSK_PCI_CMD   = 32'h0401_FC0F;

    localparam int ENDIAN_BIT = 12;

    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        case (idx)
            IDX_CPU_CFG:  return 32'h0000_1000;
            IDX_MULTI:    return 32'h0000_0003;
            IDX_IO_LO:    return 32'h0000_0080;
            IDX_IO_HI:    return 32'h0000_000F;
            IDX_ISD:      return 32'h0000_00A0;
            IDX_IO_REMAP: return 32'h0000_0080;
            default:      return '0;
        endcase
    endfunction

endpackage

// File: rtl/hb_byte_swap.sv
module hb_byte_swap #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    logic [W-1:0] rev;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/hb_win_decode.sv
module hb_win_decode #(
    parameter int LOW_W  = 15,
    parameter int HIGH_W = 7,
    parameter int SHIFT  = 21
) (
    input  logic [LOW_W-1:0]          low_val,
    input  logic [HIGH_W-1:0]         high_val,
    output logic [LOW_W+SHIFT-1:0]    base,
    output logic [HIGH_W+SHIFT:0]     size,
    output logic                      valid
);
    localparam int SPAN_W = HIGH_W + 1;

    logic [HIGH_W-1:0] low_trim;
    logic [SPAN_W-1:0] span;

    assign low_trim = low_val[HIGH_W-1:0];
    assign valid    = (low_trim <= high_val);
    assign span     = {1'b0, high_val} + SPAN_W'(1) - {1'b0, low_trim};
    assign base     = {low_val, {SHIFT{1'b0}}};
    assign size     = valid ? {span, {SHIFT{1'b0}}} : '0;
endmodule

// File: rtl/hb_reg_store.sv
module hb_reg_store
    import hb_regbank_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] cfg_word,
    output logic [DATA_W-1:0] io_lo_word,
    output logic [DATA_W-1:0] io_hi_word
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] cause_and;

    assign cause_and  = mem[IDX_CAUSE] & wdata;
    assign rword      = mem[idx];
    assign cfg_word   = mem[IDX_CPU_CFG];
    assign io_lo_word = mem[IDX_IO_LO];
    assign io_hi_word = mem[IDX_IO_HI];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= reset_word(i);
            end
        end else if (we) begin
            unique case (int'(idx))
                IDX_IO_LO: begin
                    mem[IDX_IO_LO]    <= wdata & MSK_IO_LO;
                    mem[IDX_IO_REMAP] <= wdata & MSK_REMAP;
                end
                IDX_IO_HI:     mem[IDX_IO_HI]     <= wdata & MSK_IO_HI;
                IDX_ISD:       mem[IDX_ISD]       <= wdata & MSK_ISD;
                IDX_INT_MASK:  mem[IDX_INT_MASK]  <= wdata & MSK_INT_MASK;
                IDX_PCI_IMASK: mem[IDX_PCI_IMASK] <= wdata & MSK_PCI_IMASK;
                IDX_SERR_MASK: mem[IDX_SERR_MASK] <= wdata & MSK_SERR_MASK;
                IDX_PCI_CMD:   mem[IDX_PCI_CMD]   <= wdata & MSK_PCI_CMD;
                IDX_CAUSE:
                    mem[IDX_CAUSE] <= {cause_and[DATA_W-1:1], |cause_and[DATA_W-1:1]};
                IDX_MULTI, IDX_ERR_LO, IDX_ERR_HI, IDX_SYNC0, IDX_SYNC1: ;
                default:       mem[idx] <= wdata;
            endcase
        end
    end
endmodule

// File: rtl/hb_regbank.sv
module hb_regbank
    import hb_regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WIN_SHIFT = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [14+WIN_SHIFT:0] win_base,
    output logic [7+WIN_SHIFT:0]  win_size,
    output logic              win_valid
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int LOW_W  = 15;
    localparam int HIGH_W = 7;

    rsp_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx;
    logic              rd_req, wr_req, swap_en;
    logic [DATA_W-1:0] wdata_sw, rword, rword_sw, rdata_q;
    logic [DATA_W-1:0] cfg_word, io_lo_word, io_hi_word;
    logic [1:0]        unused_byte_lane;

    assign idx              = req_addr[ADDR_W-1:2];
    assign unused_byte_lane = req_addr[1:0];
    assign rd_req           = req_valid && !req_write;
    assign wr_req           = req_valid && req_write;
    assign swap_en          = !cfg_word[ENDIAN_BIT];

    hb_byte_swap #(.W(DATA_W)) u_wswap (
        .en(swap_en), .din(req_wdata), .dout(wdata_sw)
    );

    hb_byte_swap #(.W(DATA_W)) u_rswap (
        .en(swap_en), .din(rword), .dout(rword_sw)
    );

    hb_reg_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_req), .idx(idx), .wdata(wdata_sw),
        .rword(rword), .cfg_word(cfg_word),
        .io_lo_word(io_lo_word), .io_hi_word(io_hi_word)
    );

    hb_win_decode #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .SHIFT(WIN_SHIFT)) u_win (
        .low_val(io_lo_word[LOW_W-1:0]), .high_val(io_hi_word[HIGH_W-1:0]),
        .base(win_base), .size(win_size), .valid(win_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req)  state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rword_sw;
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/hb_regbank_chk.sv
module hb_regbank_chk #(
    parameter int WIN_SHIFT = 21
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  rsp_valid,
    input logic [14+WIN_SHIFT:0] win_base,
    input logic [7+WIN_SHIFT:0]  win_size,
    input logic                  win_valid
);
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R3

    AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R3

    AST_VALID_WIN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_size != '0)); // R10

    AST_INVALID_WIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_size == '0)); // R10

    AST_WIN_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> ($stable(win_base) && $stable(win_size) && $stable(win_valid))); // R4
endmodule

bind hb_regbank hb_regbank_chk #(.WIN_SHIFT(WIN_SHIFT)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rsp_valid(rsp_valid), .win_base(win_base), .win_size(win_size),
    .win_valid(win_valid)
);

// File: tb/hb_regbank_tb_top.sv
module hb_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [35:0] win_base;
    logic [28:0] win_size;
    logic        win_valid;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] ref_mem [1024];
    logic        exp_rv;
    logic [31:0] exp_rd;

    always #5 clk = ~clk;

    hb_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .win_base(win_base), .win_size(win_size),
        .win_valid(win_valid)
    );

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    // R1 reset image
    task automatic model_reset();
        for (int i = 0; i < 1024; i++) ref_mem[i] = 32'h0;
        ref_mem['h000] = 32'h0000_1000;
        ref_mem['h048] = 32'h3;
        ref_mem['h012] = 32'h80;
        ref_mem['h014] = 32'h0F;
        ref_mem['h01A] = 32'hA0;
        ref_mem['h03C] = 32'h80;
        exp_rv = 1'b0;
        exp_rd = 32'h0;
    endtask

    task automatic model_write(input int w, input logic [31:0] raw);
        logic [31:0] d;
        logic [31:0] c;
        d = ref_mem[0][12] ? raw : bswap(raw); // R9
        case (w)
            'h012: begin ref_mem['h012] = d & 32'h7FFF; ref_mem['h03C] = d & 32'h7FF; end // R4
            'h014: ref_mem[w] = d & 32'h7F;        // R5
            'h01A: ref_mem[w] = d & 32'h7FFF;      // R5
            'h307: ref_mem[w] = d & 32'h3C3F_FFFE; // R6
            'h309: ref_mem[w] = d & 32'h03FF_FFFE; // R6
            'h30A: ref_mem[w] = d & 32'h3F;        // R6
            'h300: ref_mem[w] = d & 32'h0401_FC0F; // R6
            'h306: begin                           // R7
                c = ref_mem[w] & d;
                c[0] = (c[31:1] != 0);
                ref_mem[w] = c;
            end
            'h048, 'h01C, 'h01E, 'h030, 'h032: ;   // R8
            default: ref_mem[w] = d;               // R11
        endcase
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [14:0] lo;
        logic [6:0]  hi;
        logic        v;
        logic [63:0] sz;
        lo = ref_mem['h012][14:0];
        hi = ref_mem['h014][6:0];
        v  = (lo[6:0] <= hi);
        sz = v ? ((64'(hi) + 64'd1 - 64'(lo[6:0])) << 21) : 64'd0;
        check("R3 rsp_valid", 64'(rsp_valid), 64'(exp_rv));
        if (exp_rv) check(tag, 64'(rsp_rdata), 64'(exp_rd));
        check("R10 win_base", 64'(win_base), 64'(lo) << 21);
        check("R10 win_size", 64'(win_size), sz);
        check("R10 win_valid", 64'(win_valid), 64'(v));
    endtask

    task automatic step(input logic v, input logic w, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        exp_rv = v && !w;
        if (v && !w) exp_rd = ref_mem[0][12] ? ref_mem[a[11:2]] : bswap(ref_mem[a[11:2]]);
        if (v && w) model_write(int'(a[11:2]), d);
        compare_all(tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 12'h0, 32'h0, "idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1 reset state");

        // R1 reset values
        rd(12'h000, "R1 cpu cfg");
        rd(12'h120, "R1 multi");
        rd(12'h048, "R1 io low");
        rd(12'h050, "R1 io high");
        rd(12'h068, "R1 isd");
        rd(12'h0F0, "R1 remap");
        rd(12'hC00, "R1 pci cmd");
        idle();

        // R4 low decode with shadow
        wr(12'h048, 32'hFFFF_FFFF, "R4 io low");
        rd(12'h048, "R4 io low");
        rd(12'h0F0, "R4 remap shadow");
        // R5 high decode / isd
        wr(12'h050, 32'hFFFF_FFFF, "R5 io high");
        rd(12'h050, "R5 io high");
        wr(12'h068, 32'hFFFF_FFFF, "R5 isd");
        rd(12'h068, "R5 isd");
        // R10 boundaries
        wr(12'h048, 32'h0000_0023, "R10 low");
        wr(12'h050, 32'h0000_0022, "R10 high below low");
        wr(12'h050, 32'h0000_0023, "R10 high equal low");
        wr(12'h050, 32'h0000_0024, "R10 high above low");
        wr(12'h048, 32'h0000_1F80, "R10 upper low bits");
        idle();

        // R6 masks
        wr(12'hC1C, 32'hFFFF_FFFF, "R6 int mask");
        wr(12'hC24, 32'hFFFF_FFFF, "R6 pci imask");
        wr(12'hC28, 32'hFFFF_FFFF, "R6 serr");
        wr(12'hC00, 32'hFFFF_FFFF, "R6 cmd");
        rd(12'hC1C, "R6 int mask");
        rd(12'hC24, "R6 pci imask");
        rd(12'hC28, "R6 serr");
        rd(12'hC00, "R6 cmd");

        // R7 cause
        wr(12'hC18, 32'hFFFF_FFFF, "R7 cause");
        rd(12'hC18, "R7 cause");
        wr(12'hC18, 32'h0000_0000, "R7 cause");
        rd(12'hC18, "R7 cause");

        // R8 read-only
        wr(12'h120, 32'h1234_5678, "R8 multi");
        wr(12'h070, 32'hFFFF_FFFF, "R8 err lo");
        wr(12'h078, 32'hFFFF_FFFF, "R8 err hi");
        wr(12'h0C0, 32'hFFFF_FFFF, "R8 sync0");
        wr(12'h0C8, 32'hFFFF_FFFF, "R8 sync1");
        rd(12'h120, "R8 multi");
        rd(12'h070, "R8 err lo");
        rd(12'h078, "R8 err hi");
        rd(12'h0C0, "R8 sync0");
        rd(12'h0C8, "R8 sync1");

        // R11 plain storage, R2 byte lanes ignored
        wr(12'h200, 32'hDEAD_BEEF, "R11 plain");
        rd(12'h200, "R11 plain");
        rd(12'h203, "R2 lane bits");
        wr(12'h3FE, 32'hCAFE_F00D, "R2 lane write");
        rd(12'h3FC, "R2 lane write");
        rd(12'hFFC, "R11 top word");
        idle();

        // R9 byte order
        wr(12'h000, 32'h0000_0000, "R9 enter swap");
        wr(12'h204, 32'h1122_3344, "R9 swapped write");
        rd(12'h204, "R9 swapped read");
        rd(12'h200, "R9 swapped old");
        wr(12'h050, 32'h0500_0000, "R9 swapped high");
        wr(12'h048, 32'h0300_0000, "R9 swapped low");
        rd(12'h000, "R9 cfg read");
        wr(12'h000, 32'h0010_0000, "R9 leave swap");
        rd(12'h204, "R9 native read");
        rd(12'h050, "R9 native high");
        idle();
        idle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule